// File: doc/BRIEF.md
# Virtually Indexed, Physically Tagged Data Cache

This block is a direct-mapped, write-back level-one data cache for a 32-bit address space. A load or store arrives with its virtual address, and the cache reads the candidate line from that address at once. The translated physical address comes in on a separate input one cycle later. The stored tag is compared against the physical page number in that second cycle. A hit answers in the following cycle and touches no memory. A miss first writes back a dirty victim, then refills the line over a line-wide memory port with a valid/ready handshake. Stores that miss allocate the line.

The default geometry is 64-byte lines, 512 lines and 8 KB pages. With it, two address bits are both line-select bits and page-number bits. These two bits form the page color. A request whose virtual and physical colors differ is flagged on the response. It is still served at the line picked by its virtual address. Only one request is in flight at a time.

Top module: `vipt_cache`

## Requirements
- R1: After reset, or a later reset, every line is invalid, so the first access to any address misses. Directly after reset, `req_ready_o` is 1, `rsp_valid_o` is 0 and `mem_valid_o` is 0.
- R2: The line is chosen by virtual address bits 14:6 only. Bits 5:2 pick the 32-bit word inside the line. Virtual bits 31:15 play no part, so two virtual addresses that differ only there hit the same line.
- R3: A load hits when the chosen line is valid and its stored tag equals `paddr_i[31:13]`. `paddr_i` is sampled in the cycle after the request is accepted. On a hit, `rsp_valid_o` is 1 in the next cycle, with `rsp_hit_o`=1 and the word in `rsp_rdata_o`, and `mem_valid_o` stays 0.
- R4: A load miss on a line that is not dirty issues one read (`mem_we_o`=0) at address `{paddr[31:6], 6'b0}`. After the handshake the cache waits for `mem_rvalid_i`. One cycle after `mem_rvalid_i`, it responds with `rsp_hit_o`=0 and the requested word of `mem_rdata_i`. Word w sits at bits `w*32 +: 32`.
- R5: A store hit writes only the bytes whose bit is set in `req_be_i` (bit b selects bits `8b+7:8b`) and makes no memory access. Later loads return the merged word.
- R6: A store miss fetches the line, merges the store bytes into it and marks it dirty. The response carries the merged word, and so does any later load that hits.
- R7: A miss on a valid, dirty line first writes the old line (`mem_we_o`=1) at `{stored tag, vaddr[12:6], 6'b0}`, with the old line on `mem_wdata_o`. Only after that handshake does it issue the refill read.
- R8: A miss on a valid, clean line issues no write; its first memory request is the refill read.
- R9: When `vaddr[14:13]` differs from `paddr[14:13]`, `color_err_o` is 1 together with that request's `rsp_valid_o`, and the request is still served at the virtual index. `color_err_o` is 0 at all other times.
- R10: `req_ready_o` is 0 from the cycle after acceptance until the cycle after the response. Requests presented meanwhile are ignored and change no line.
- R11: Once raised, `mem_valid_o` stays 1 with stable `mem_addr_o` and `mem_we_o` until `mem_ready_i` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Cache can accept a request |
| req_vaddr_i | input | 32 | Virtual byte address, word aligned |
| req_we_i | input | 1 | 1 = store, 0 = load |
| req_wdata_i | input | 32 | Store data |
| req_be_i | input | 4 | Store byte enables |
| paddr_i | input | 32 | Translated address, valid the cycle after acceptance |
| rsp_valid_o | output | 1 | Response pulse |
| rsp_rdata_o | output | 32 | Addressed word (after any store merge) |
| rsp_hit_o | output | 1 | Request hit without memory traffic |
| color_err_o | output | 1 | Virtual and physical page colors differ |
| mem_valid_o | output | 1 | Memory request valid |
| mem_ready_i | input | 1 | Memory accepts the request |
| mem_we_o | output | 1 | 1 = line write-back, 0 = line read |
| mem_addr_o | output | 32 | Line-aligned memory address |
| mem_wdata_o | output | 512 | Write-back line |
| mem_rvalid_i | input | 1 | Refill data present |
| mem_rdata_i | input | 512 | Refill line |

## Verification
The properties take for granted that the memory side raises `mem_rvalid_i` only while a refill read is outstanding, and only after that read has been accepted. They also assume `paddr_i` carries the translation in exactly the cycle after acceptance. The bench's memory model keeps `mem_ready_i` low until it has seen `mem_valid_o`, and it pulses `mem_rvalid_i` for one cycle only after a refill handshake. Between accepted requests the bench drives `req_valid_i` only as deliberate noise while the cache is busy. Virtual and physical colors are kept equal, except in the cases that test R9.

// File: rtl/vipt_pkg.sv
package vipt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_WBACK,
    ST_FILL_REQ,
    ST_FILL_WAIT,
    ST_RESP
  } cache_state_e;
endpackage

// File: rtl/vipt_line_merge.sv
module vipt_line_merge #(
  parameter int WORD_W = 32,
  parameter int WORDS  = 16,
  localparam int BE_W   = WORD_W / 8,
  localparam int LINE_W = WORD_W * WORDS,
  localparam int WIDX_W = $clog2(WORDS)
) (
  input  logic [LINE_W-1:0] line_i,
  input  logic              en_i,
  input  logic [WIDX_W-1:0] widx_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [BE_W-1:0]   be_i,
  output logic [LINE_W-1:0] line_o,
  output logic [WORD_W-1:0] word_o
);
  for (genvar w = 0; w < WORDS; w++) begin : g_word
    for (genvar b = 0; b < BE_W; b++) begin : g_byte
      assign line_o[w*WORD_W+b*8 +: 8] =
        (en_i && widx_i == WIDX_W'(w) && be_i[b]) ? wdata_i[b*8 +: 8]
                                                   : line_i[w*WORD_W+b*8 +: 8];
    end
  end

  assign word_o = line_o[widx_i*WORD_W +: WORD_W];
endmodule

// File: rtl/vipt_tag_store.sv
module vipt_tag_store #(
  parameter int LINES = 512,
  parameter int TAG_W = 19,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rd_en_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic             fill_en_i,
  input  logic [TAG_W-1:0] fill_tag_i,
  input  logic             fill_dirty_i,
  input  logic             mark_dirty_i,
  output logic [TAG_W-1:0] rd_tag_o,
  output logic             rd_valid_o,
  output logic             rd_dirty_o
);
  logic [TAG_W-1:0] tag_mem [LINES];
  logic [LINES-1:0] valid_q, dirty_q;

  always_ff @(posedge clk_i) begin
    if (fill_en_i) tag_mem[wr_idx_i] <= fill_tag_i;
    if (rd_en_i)   rd_tag_o <= tag_mem[rd_idx_i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q    <= '0;
      dirty_q    <= '0;
      rd_valid_o <= 1'b0;
      rd_dirty_o <= 1'b0;
    end else begin
      if (fill_en_i) begin
        valid_q[wr_idx_i] <= 1'b1;
        dirty_q[wr_idx_i] <= fill_dirty_i;
      end
      if (mark_dirty_i) dirty_q[wr_idx_i] <= 1'b1;
      if (rd_en_i) begin
        rd_valid_o <= valid_q[rd_idx_i];
        rd_dirty_o <= dirty_q[rd_idx_i];
      end
    end
  end
endmodule

// File: rtl/vipt_data_store.sv
module vipt_data_store #(
  parameter int LINES  = 512,
  parameter int LINE_W = 512,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic              clk_i,
  input  logic              rd_en_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [LINE_W-1:0] wr_line_i,
  output logic [LINE_W-1:0] rd_line_o
);
  logic [LINE_W-1:0] line_mem [LINES];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) line_mem[wr_idx_i] <= wr_line_i;
    if (rd_en_i) rd_line_o <= line_mem[rd_idx_i];
  end
endmodule

// File: rtl/vipt_ctrl.sv
module vipt_ctrl
  import vipt_pkg::*;
(
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         req_fire_i,
  input  logic         hit_i,
  input  logic         victim_dirty_i,
  input  logic         mem_ready_i,
  input  logic         mem_rvalid_i,
  output cache_state_e state_o
);
  cache_state_e state_d;

  always_comb begin
    state_d = state_o;
    unique case (state_o)
      ST_IDLE:      if (req_fire_i) state_d = ST_LOOKUP;
      ST_LOOKUP: begin
        if (hit_i)               state_d = ST_RESP;
        else if (victim_dirty_i) state_d = ST_WBACK;
        else                     state_d = ST_FILL_REQ;
      end
      ST_WBACK:     if (mem_ready_i)  state_d = ST_FILL_REQ;
      ST_FILL_REQ:  if (mem_ready_i)  state_d = ST_FILL_WAIT;
      ST_FILL_WAIT: if (mem_rvalid_i) state_d = ST_RESP;
      ST_RESP:      state_d = ST_IDLE;
      default:      state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_o <= ST_IDLE;
    else         state_o <= state_d;
  end
endmodule

// File: rtl/vipt_cache.sv
module vipt_cache
  import vipt_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int LINES      = 512,
  parameter int PAGE_BYTES = 8192,
  localparam int OFF_W   = $clog2(LINE_BYTES),
  localparam int IDX_W   = $clog2(LINES),
  localparam int PG_W    = $clog2(PAGE_BYTES),
  localparam int TAG_W   = ADDR_W - PG_W,
  localparam int LINE_W  = LINE_BYTES * 8,
  localparam int BE_W    = WORD_W / 8,
  localparam int WORDS   = LINE_BYTES / BE_W,
  localparam int WIDX_W  = $clog2(WORDS),
  localparam int BSEL_W  = $clog2(BE_W),
  localparam int VA_W    = OFF_W + IDX_W,
  localparam int COLOR_W = VA_W - PG_W,
  localparam int LOW_W   = PG_W - OFF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_vaddr_i,
  input  logic              req_we_i,
  input  logic [WORD_W-1:0] req_wdata_i,
  input  logic [BE_W-1:0]   req_be_i,
  input  logic [ADDR_W-1:0] paddr_i,
  output logic              rsp_valid_o,
  output logic [WORD_W-1:0] rsp_rdata_o,
  output logic              rsp_hit_o,
  output logic              color_err_o,
  output logic              mem_valid_o,
  input  logic              mem_ready_i,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [LINE_W-1:0] mem_wdata_o,
  input  logic              mem_rvalid_i,
  input  logic [LINE_W-1:0] mem_rdata_i
);
  cache_state_e state;

  logic [VA_W-1:0]        va_q;
  logic                   we_q;
  logic [WORD_W-1:0]      wdata_q;
  logic [BE_W-1:0]        be_q;
  logic [ADDR_W-OFF_W-1:0] paddr_q;
  logic                   hit_q, color_q;
  logic [WORD_W-1:0]      rsp_word_q;

  logic [TAG_W-1:0]  rd_tag;
  logic              rd_valid, rd_dirty;
  logic [LINE_W-1:0] rd_line, merge_src, merged_line;
  logic [WORD_W-1:0] merged_word;
  logic              req_fire, tag_match, lookup_hit, fill_done, color_mis;
  logic [IDX_W-1:0]  idx_q;

  assign req_fire   = req_valid_i && (state == ST_IDLE);
  assign idx_q      = va_q[OFF_W +: IDX_W];
  assign tag_match  = rd_valid && (rd_tag == paddr_i[ADDR_W-1:PG_W]);
  assign lookup_hit = (state == ST_LOOKUP) && tag_match;
  assign fill_done  = (state == ST_FILL_WAIT) && mem_rvalid_i;

  if (COLOR_W > 0) begin : g_color
    assign color_mis = va_q[PG_W +: COLOR_W] != paddr_i[PG_W +: COLOR_W];
  end else begin : g_no_color
    assign color_mis = 1'b0;
  end

  vipt_ctrl u_ctrl (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .req_fire_i     (req_fire),
    .hit_i          (tag_match),
    .victim_dirty_i (rd_valid && rd_dirty),
    .mem_ready_i    (mem_ready_i),
    .mem_rvalid_i   (mem_rvalid_i),
    .state_o        (state)
  );

  // line is read with the virtual index before the translation arrives
  vipt_tag_store #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rd_en_i      (req_fire),
    .rd_idx_i     (req_vaddr_i[OFF_W +: IDX_W]),
    .wr_idx_i     (idx_q),
    .fill_en_i    (fill_done),
    .fill_tag_i   (paddr_q[ADDR_W-OFF_W-1:PG_W-OFF_W]),
    .fill_dirty_i (we_q),
    .mark_dirty_i (lookup_hit && we_q),
    .rd_tag_o     (rd_tag),
    .rd_valid_o   (rd_valid),
    .rd_dirty_o   (rd_dirty)
  );

  vipt_data_store #(.LINES(LINES), .LINE_W(LINE_W)) u_data (
    .clk_i     (clk_i),
    .rd_en_i   (req_fire),
    .rd_idx_i  (req_vaddr_i[OFF_W +: IDX_W]),
    .wr_en_i   ((lookup_hit && we_q) || fill_done),
    .wr_idx_i  (idx_q),
    .wr_line_i (merged_line),
    .rd_line_o (rd_line)
  );

  assign merge_src = (state == ST_FILL_WAIT) ? mem_rdata_i : rd_line;

  vipt_line_merge #(.WORD_W(WORD_W), .WORDS(WORDS)) u_merge (
    .line_i  (merge_src),
    .en_i    (we_q),
    .widx_i  (va_q[BSEL_W +: WIDX_W]),
    .wdata_i (wdata_q),
    .be_i    (be_q),
    .line_o  (merged_line),
    .word_o  (merged_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      va_q       <= '0;
      we_q       <= 1'b0;
      wdata_q    <= '0;
      be_q       <= '0;
      paddr_q    <= '0;
      hit_q      <= 1'b0;
      color_q    <= 1'b0;
      rsp_word_q <= '0;
    end else begin
      if (req_fire) begin
        va_q    <= req_vaddr_i[VA_W-1:0];
        we_q    <= req_we_i;
        wdata_q <= req_wdata_i;
        be_q    <= req_be_i;
      end
      if (state == ST_LOOKUP) begin
        paddr_q <= paddr_i[ADDR_W-1:OFF_W];
        hit_q   <= tag_match;
        color_q <= color_mis;
      end
      if (lookup_hit || fill_done) rsp_word_q <= merged_word;
    end
  end

  assign req_ready_o = (state == ST_IDLE);
  assign rsp_valid_o = (state == ST_RESP);
  assign rsp_rdata_o = rsp_word_q;
  assign rsp_hit_o   = hit_q;
  assign color_err_o = color_q && rsp_valid_o;

  // victim address: stored page number plus the page-offset part of the index
  assign mem_valid_o = (state == ST_WBACK) || (state == ST_FILL_REQ);
  assign mem_we_o    = (state == ST_WBACK);
  assign mem_addr_o  = mem_we_o ? {rd_tag, va_q[OFF_W +: LOW_W], {OFF_W{1'b0}}}
                                : {paddr_q, {OFF_W{1'b0}}};
  assign mem_wdata_o = rd_line;

  logic unused_bits;
  assign unused_bits = ^{req_vaddr_i[ADDR_W-1:VA_W], paddr_i[OFF_W-1:0], va_q[BSEL_W-1:0]};
endmodule

// File: rtl/vipt_cache_chk.sv
module vipt_cache_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic              rsp_valid_o,
  input logic              rsp_hit_o,
  input logic              color_err_o,
  input logic              mem_valid_o,
  input logic              mem_ready_i,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_rvalid_i
);
  // R3
  hit_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_hit_o |-> $past(req_valid_i && req_ready_o, 2));

  // R4
  fill_to_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_hit_o |-> $past(mem_rvalid_i));

  // R7
  wb_then_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o && mem_we_o && mem_ready_i |=> mem_valid_o && !mem_we_o);

  // R9
  color_with_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    color_err_o |-> rsp_valid_o);

  // R10
  busy_no_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_valid_o || rsp_valid_o) |-> !req_ready_o);

  // R10
  ready_after_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> req_ready_o && !rsp_valid_o);

  // R11
  mem_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o && !mem_ready_i |=> mem_valid_o && $stable(mem_addr_o) && $stable(mem_we_o));
endmodule

bind vipt_cache vipt_cache_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/vipt_cache_test.sv
module vipt_cache_test;
  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         req_valid_i = 1'b0;
  logic         req_ready_o;
  logic [31:0]  req_vaddr_i = '0;
  logic         req_we_i = 1'b0;
  logic [31:0]  req_wdata_i = '0;
  logic [3:0]   req_be_i = '0;
  logic [31:0]  paddr_i = '1;
  logic         rsp_valid_o;
  logic [31:0]  rsp_rdata_o;
  logic         rsp_hit_o;
  logic         color_err_o;
  logic         mem_valid_o;
  logic         mem_ready_i = 1'b0;
  logic         mem_we_o;
  logic [31:0]  mem_addr_o;
  logic [511:0] mem_wdata_o;
  logic         mem_rvalid_i = 1'b0;
  logic [511:0] mem_rdata_i = '0;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  vipt_cache uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o), .req_vaddr_i(req_vaddr_i),
    .req_we_i(req_we_i), .req_wdata_i(req_wdata_i), .req_be_i(req_be_i),
    .paddr_i(paddr_i),
    .rsp_valid_o(rsp_valid_o), .rsp_rdata_o(rsp_rdata_o), .rsp_hit_o(rsp_hit_o),
    .color_err_o(color_err_o),
    .mem_valid_o(mem_valid_o), .mem_ready_i(mem_ready_i), .mem_we_o(mem_we_o),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
    .mem_rvalid_i(mem_rvalid_i), .mem_rdata_i(mem_rdata_i)
  );

  // behavioural reference state
  logic [511:0] c_data [512];
  logic [18:0]  c_tag  [512];
  bit           c_valid[512];
  bit           c_dirty[512];
  logic [511:0] mem_m [int unsigned];

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  function automatic logic [511:0] memline(input int unsigned la);
    logic [511:0] l;
    if (mem_m.exists(la)) return mem_m[la];
    for (int w = 0; w < 16; w++) l[w*32 +: 32] = (la*64 + w*4) ^ 32'h3C5A_0F96;
    return l;
  endfunction

  task automatic mem_hs(input int dly, input logic [31:0] exp_addr, input bit exp_we);
    for (int i = 0; i < dly; i++) begin
      @(negedge clk);
      chk(mem_valid_o && mem_addr_o == exp_addr && mem_we_o == exp_we, "R11",
          "request held", {mem_valid_o, mem_we_o, mem_addr_o}, {2'b1, exp_we, exp_addr});
    end
    mem_ready_i = 1'b1;
    @(negedge clk);
    mem_ready_i = 1'b0;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    req_valid_i = 1'b0; mem_ready_i = 1'b0; mem_rvalid_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    for (int i = 0; i < 512; i++) begin c_valid[i] = 1'b0; c_dirty[i] = 1'b0; end
    chk(req_ready_o && !rsp_valid_o && !mem_valid_o, "R1", "reset outputs",
        {req_ready_o, rsp_valid_o, mem_valid_o}, 3'b100);
  endtask

  // starts and ends at a negedge with the cache idle
  task automatic access(input logic [31:0] va, input logic [31:0] pa, input bit we,
                        input logic [31:0] wd, input logic [3:0] be, input int dly,
                        input bit noise, input string ov);
    int idx = int'(va[14:6]);
    int w = int'(va[5:2]);
    logic [18:0] tg = pa[31:13];
    bit hit = c_valid[idx] && c_tag[idx] == tg;
    bit col = va[14:13] != pa[14:13];
    bit wb = !hit && c_valid[idx] && c_dirty[idx];
    logic [511:0] line;
    logic [31:0] ea;
    string rq = (ov != "") ? ov : hit ? (we ? "R5" : "R3") : (we ? "R6" : "R4");

    chk(req_ready_o, "R10", "ready when idle", req_ready_o, 1);
    req_valid_i = 1'b1; req_vaddr_i = va; req_we_i = we; req_wdata_i = wd; req_be_i = be;
    @(negedge clk);
    req_valid_i = 1'b0; paddr_i = pa;
    chk(!req_ready_o && !rsp_valid_o && !mem_valid_o, "R10", "lookup cycle",
        {req_ready_o, rsp_valid_o, mem_valid_o}, 0);
    @(negedge clk);
    paddr_i = 32'hFFFF_FFFF;
    if (hit) begin
      line = c_data[idx];
      chk(!mem_valid_o, rq, "no memory on hit", mem_valid_o, 0);
    end else begin
      if (wb) begin
        ea = {c_tag[idx], va[12:6], 6'b0};
        chk(mem_valid_o && mem_we_o && mem_addr_o == ea, "R7", "write-back request",
            {mem_valid_o, mem_we_o, mem_addr_o}, {2'b11, ea});
        chk(mem_wdata_o == c_data[idx], "R7", "write-back data",
            mem_wdata_o[63:0], c_data[idx][63:0]);
        mem_hs(dly, ea, 1'b1);
        mem_m[ea >> 6] = c_data[idx];
      end
      ea = {pa[31:6], 6'b0};
      chk(mem_valid_o && !mem_we_o && mem_addr_o == ea, wb ? "R7" : (c_valid[idx] ? "R8" : "R4"),
          "refill request", {mem_valid_o, mem_we_o, mem_addr_o}, {2'b10, ea});
      mem_hs(dly, ea, 1'b0);
      for (int i = 0; i <= dly; i++) begin
        chk(!mem_valid_o && !rsp_valid_o && !req_ready_o, "R10", "refill wait",
            {mem_valid_o, rsp_valid_o, req_ready_o}, 0);
        if (noise) begin
          req_valid_i = 1'b1; req_vaddr_i = va ^ 32'h100; req_we_i = 1'b1;
          req_wdata_i = 32'hDEAD_BEEF; req_be_i = 4'hF;
        end
        @(negedge clk);
      end
      req_valid_i = 1'b0;
      line = memline(ea >> 6);
      mem_rvalid_i = 1'b1; mem_rdata_i = line;
      @(negedge clk);
      mem_rvalid_i = 1'b0; mem_rdata_i = '0;
    end
    if (we) for (int b = 0; b < 4; b++) if (be[b]) line[w*32+b*8 +: 8] = wd[b*8 +: 8];
    chk(rsp_valid_o && rsp_hit_o == hit, rq, "response/hit", {rsp_valid_o, rsp_hit_o}, {1'b1, hit});
    chk(rsp_rdata_o == line[w*32 +: 32], rq, "response word", rsp_rdata_o, line[w*32 +: 32]);
    chk(color_err_o == col, col ? "R9" : rq, "color flag", color_err_o, col);
    c_data[idx] = line;
    c_tag[idx] = tg;
    c_dirty[idx] = hit ? (c_dirty[idx] | we) : we;
    c_valid[idx] = 1'b1;
    @(negedge clk);
    chk(!rsp_valid_o && !color_err_o, "R9", "flag only with response", {rsp_valid_o, color_err_o}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [8:0]  idx_set [3];
    logic [16:0] tsel_set[3];
    idx_set = '{9'h041, 9'h0FE, 9'h1FF};
    tsel_set = '{17'h00011, 17'h0ABCD, 17'h1F00F};
    @(negedge clk);
    do_reset();
    // R1 R4: cold miss
    access(32'h0000_1044, 32'h0004_1044, 0, 0, 0, 1, 0, "R1");
    access(32'h0000_1048, 32'h0004_1048, 0, 0, 0, 0, 0, "");
    // R2: upper virtual bits do not affect the line
    access(32'h8000_1044, 32'h0004_1044, 0, 0, 0, 0, 0, "R2");
    access(32'h0000_1044, 32'h0004_1044, 1, 32'h1122_3344, 4'b0101, 0, 0, "");
    access(32'h0000_1044, 32'h0004_1044, 0, 0, 0, 0, 0, "R5");
    // R7 dirty victim, R11 delayed handshakes
    access(32'h0000_1044, 32'h0009_1044, 0, 0, 0, 2, 0, "R7");
    // R8 clean victim; A returns with stored bytes from memory
    access(32'h0000_1044, 32'h0004_1044, 0, 0, 0, 1, 0, "R8");
    // R6 store miss with R10 noise during refill
    access(32'h0000_3F80, 32'h0012_3F80, 1, 32'hCAFE_F00D, 4'b1110, 1, 1, "R6");
    access(32'h0000_3E80, 32'h0012_3E80, 0, 0, 0, 0, 0, "R10");
    access(32'h0000_3F80, 32'h0012_3F80, 0, 0, 0, 0, 0, "R6");
    // R9 color mismatch, served at the virtual index
    access(32'h0000_2080, 32'h0010_4080, 0, 0, 0, 0, 0, "R9");
    access(32'h0000_2084, 32'h0010_4084, 0, 0, 0, 0, 0, "R9");
    access(32'h0000_3F80, 32'h0056_3F80, 0, 0, 0, 0, 0, "R7");
    for (int n = 0; n < 300; n++) begin
      logic [8:0] ix = idx_set[$urandom_range(0, 2)];
      logic [31:0] va = {$urandom_range(0, 32'h1FFFF), ix, 4'($urandom_range(0, 15)), 2'b00};
      logic [31:0] pa = {tsel_set[$urandom_range(0, 2)], va[14:13], va[12:0]};
      access(va, pa, 1'($urandom_range(0, 1)), $urandom, 4'($urandom_range(0, 15)),
             $urandom_range(0, 2), 1'($urandom_range(0, 1)), "");
    end
    do_reset();
    // R1: line valid before reset misses afterwards
    access(32'h0000_1044, 32'h0004_1044, 0, 0, 0, 0, 0, "R1");
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule